// File: doc/BRIEF.md
# Single-Address DMA Channel Sequencer

This block is one DMA channel that moves data between external memory and an external device without ever latching the data itself. The channel owns the bus only for the memory access. It drives the memory address together with a read or write strobe. At the same time it raises an acknowledge toward the device, which then sources or sinks the data directly. Each rising edge on the request input starts exactly one transfer of a byte or a word. Between transfers the channel returns the bus to the processor.

The address and a 16-bit transfer count are loaded through a configuration strobe. Transfer size, port width, direction and the end-of-transfer output enable are static mode inputs, captured when a transfer starts. A word moved over an 8-bit port becomes two byte accesses, upper byte first, under one unbroken acknowledge. The transfer that brings the count to zero can raise an end-of-transfer output. That transfer is followed by one idle dead state before the bus is released and a done flag is set.

Top module: `sa_dma_seq`

## Requirements
- R1: After reset bus_req, mem_rd, mem_wr, dack, tend and done are low and remaining is 0.
- R2: Each rising edge of dreq while remaining is nonzero causes exactly one transfer, and remaining drops by one when that transfer ends.
- R3: bus_req is held high until bus_grant is seen, and mem_rd, mem_wr and dack are never high while bus_grant is low.
- R4: Every access lasts exactly two clock cycles. During an access mem_addr is driven, dack is high, and mem_rd is high when dir_to_mem is 0 or mem_wr is high when dir_to_mem is 1, never both.
- R5: A byte transfer (xfer_word=0) is one access and advances the address by 1. A word transfer on a 16-bit port (xfer_word=1, port_narrow=0) is one access and advances it by 2.
- R6: A word transfer on an 8-bit port (xfer_word=1, port_narrow=1) is two back-to-back accesses at A and then A+1, with dack high for all four cycles. The next transfer starts at A+2.
- R7: After each transfer bus_req is low for at least two consecutive cycles before the channel can request the bus again.
- R8: With tend_en=1, tend is high in every access cycle of the transfer that brings remaining from 1 to 0 and in no other cycle. With tend_en=0, tend stays low.
- R9: The final transfer is followed by exactly one dead cycle, in which bus_req stays high while mem_rd, mem_wr and dack are low, and then by the release. Non-final transfers have no dead cycle.
- R10: A dreq edge seen while remaining is 0 is ignored: bus_req stays low. This includes a request that arrives during the final transfer.
- R11: cfg_load sets the address and remaining, and clears done. done goes high in the release cycle that follows the dead cycle and stays high until the next cfg_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads cfg_addr and cfg_count, clears done |
| cfg_addr | input | 16 | Start memory address |
| cfg_count | input | 16 | Number of transfers |
| xfer_word | input | 1 | 1 = word transfer, 0 = byte |
| port_narrow | input | 1 | 1 = 8-bit memory port, 0 = 16-bit |
| dir_to_mem | input | 1 | 1 = device to memory (write), 0 = memory to device (read) |
| tend_en | input | 1 | Enables the end-of-transfer output |
| dreq | input | 1 | Transfer request, acted on at its rising edge |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dack | output | 1 | Acknowledge strobe to the device |
| tend | output | 1 | End-of-transfer indication |
| done | output | 1 | Count exhausted and final release reached |
| remaining | output | 16 | Transfers still to run |

## Verification
The sharpest coincidence is a fresh request that lands in the same cycles as the transfer that drives the counter to zero. The request is seen while the count is still one, and it must then be dropped once the dead cycle and the release have passed. The bench provokes this by pulsing dreq during the first access cycle of a final transfer. It then judges the outcome at the ports: bus_req must stay low for a long window, remaining must stay at zero and done must stay high. A second collision arises when grant latency and the release gap overlap. Random grant delays are applied, and each transfer is checked for strobes outside grant and for a two-cycle low on bus_req.

// File: rtl/sa_dma_pkg.sv
package sa_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_T1,
        ST_T2,
        ST_DEAD,
        ST_REL
    } dma_state_e;

    typedef struct packed {
        logic word;
        logic narrow;
        logic to_mem;
        logic tend_en;
    } xfer_mode_t;

    // Address advance after one access of the given mode.
    function automatic logic [1:0] access_step(input xfer_mode_t m);
        return (m.word && !m.narrow) ? 2'd2 : 2'd1;
    endfunction

    // True when the mode needs a second byte access.
    function automatic logic split_word(input xfer_mode_t m);
        return m.word && m.narrow;
    endfunction

endpackage

// File: rtl/sa_dma_count.sv
module sa_dma_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_last = (cnt_q == ONE);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) - ONE));

    // R10
    no_dec_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt_q != '0));

endmodule

// File: rtl/sa_dma_addr.sv
module sa_dma_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= load_val;
        else if (step_en)
            addr_q <= addr_q + ADDR_W'(step);
    end

    assign addr = addr_q;

    // R5
    addr_move_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && addr_q != $past(addr_q)) |->
        ((addr_q - $past(addr_q)) == ADDR_W'(1) || (addr_q - $past(addr_q)) == ADDR_W'(2)));

endmodule

// File: rtl/sa_dma_fsm.sv
module sa_dma_fsm
    import sa_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_load,
    input  xfer_mode_t mode_in,
    input  logic       dreq,
    input  logic       bus_grant,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output logic       bus_req,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       dack,
    output logic       tend,
    output logic       done,
    output logic       cnt_dec,
    output logic       addr_step_en,
    output logic [1:0] addr_step
);
    dma_state_e state_q, state_d;
    xfer_mode_t mode_q;
    logic       dreq_q;
    logic       pend_q;
    logic       second_q;
    logic       done_q;
    logic       req_edge;
    logic       in_access;
    logic       access_end;
    logic       xfer_end;

    assign req_edge   = dreq && !dreq_q;
    assign in_access  = (state_q == ST_T1) || (state_q == ST_T2);
    assign access_end = (state_q == ST_T2);
    assign xfer_end   = access_end && (second_q || !split_word(mode_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pend_q && !cnt_zero) state_d = ST_REQ;
            ST_REQ:  if (bus_grant)           state_d = ST_T1;
            ST_T1:                            state_d = ST_T2;
            ST_T2: begin
                if (!xfer_end)     state_d = ST_T1;
                else if (cnt_last) state_d = ST_DEAD;
                else               state_d = ST_REL;
            end
            ST_DEAD:                          state_d = ST_REL;
            ST_REL:                           state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            dreq_q   <= 1'b0;
            pend_q   <= 1'b0;
            second_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dreq_q  <= dreq;
            if (state_q == ST_IDLE && state_d == ST_REQ)
                mode_q <= mode_in;
            if (cfg_load)
                pend_q <= 1'b0;
            else if (req_edge && !cnt_zero)
                pend_q <= 1'b1;
            else if (state_q == ST_IDLE)
                pend_q <= 1'b0;
            if (xfer_end)
                second_q <= 1'b0;
            else if (access_end)
                second_q <= 1'b1;
            if (cfg_load)
                done_q <= 1'b0;
            else if (state_q == ST_DEAD)
                done_q <= 1'b1;
        end
    end

    assign bus_req      = (state_q == ST_REQ) || in_access || (state_q == ST_DEAD);
    assign dack         = in_access;
    assign mem_rd       = in_access && !mode_q.to_mem;
    assign mem_wr       = in_access && mode_q.to_mem;
    assign tend         = in_access && mode_q.tend_en && cnt_last;
    assign done         = done_q;
    assign cnt_dec      = xfer_end;
    assign addr_step_en = access_end;
    assign addr_step    = access_step(mode_q);

    // R3
    strobe_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr || dack) |-> bus_grant);

    // R4
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4
    access_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dack) |=> dack);

    // R7
    release_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |=> !bus_req);

    // R8
    tend_in_dack_chk: assert property (@(posedge clk) disable iff (rst)
        tend |-> dack);

    // R11
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt_zero && !bus_req));

endmodule

// File: rtl/sa_dma_seq.sv
module sa_dma_seq
    import sa_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              xfer_word,
    input  logic              port_narrow,
    input  logic              dir_to_mem,
    input  logic              tend_en,
    input  logic              dreq,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              dack,
    output logic              tend,
    output logic              done,
    output logic [CNT_W-1:0]  remaining
);
    xfer_mode_t mode_in;
    logic       cnt_zero;
    logic       cnt_last;
    logic       cnt_dec;
    logic       step_en;
    logic [1:0] step;

    assign mode_in = '{word: xfer_word, narrow: port_narrow,
                       to_mem: dir_to_mem, tend_en: tend_en};

    sa_dma_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg_load    (cfg_load),
        .mode_in     (mode_in),
        .dreq        (dreq),
        .bus_grant   (bus_grant),
        .cnt_zero    (cnt_zero),
        .cnt_last    (cnt_last),
        .bus_req     (bus_req),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .dack        (dack),
        .tend        (tend),
        .done        (done),
        .cnt_dec     (cnt_dec),
        .addr_step_en(step_en),
        .addr_step   (step)
    );

    sa_dma_count #(.CNT_W(CNT_W)) i_count (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .load_val(cfg_count),
        .dec     (cnt_dec),
        .count   (remaining),
        .is_zero (cnt_zero),
        .is_last (cnt_last)
    );

    sa_dma_addr #(.ADDR_W(ADDR_W)) i_addr (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .load_val(cfg_addr),
        .step_en (step_en),
        .step    (step),
        .addr    (mem_addr)
    );

endmodule

// File: tb/test_sa_dma_seq.sv
module test_sa_dma_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_count = '0;
    logic        xfer_word = 1'b0;
    logic        port_narrow = 1'b0;
    logic        dir_to_mem = 1'b0;
    logic        tend_en = 1'b0;
    logic        dreq = 1'b0;
    logic        bus_req;
    logic        bus_grant;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, dack, tend, done;
    logic [15:0] remaining;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] e_addr = '0;
    logic [15:0] e_cnt  = '0;
    int gwait = 0;

    always #2 clk = ~clk;

    sa_dma_seq i_sa_dma_seq (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .xfer_word(xfer_word), .port_narrow(port_narrow),
        .dir_to_mem(dir_to_mem), .tend_en(tend_en), .dreq(dreq),
        .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .dack(dack), .tend(tend),
        .done(done), .remaining(remaining)
    );

    // Arbiter model: grant after a random latency, dropped as soon as the request falls.
    always_ff @(posedge clk) begin
        if (rst || !bus_req) begin
            bus_grant <= 1'b0;
            gwait     <= int'($urandom_range(2, 0));
        end else if (gwait == 0) begin
            bus_grant <= 1'b1;
        end else begin
            gwait <= gwait - 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_accesses(input bit w, input bit n);
        return (w && n) ? 2 : 1;
    endfunction

    function automatic int exp_advance(input bit w);
        return w ? 2 : 1;
    endfunction

    task automatic load(input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        cfg_addr = a; cfg_count = c; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        e_addr = a; e_cnt = c;
        check(remaining == c, "R11 load count", int'(remaining), int'(c));
        check(done == 1'b0, "R11 done clear", int'(done), 0);
    endtask

    // Runs one requested transfer and checks its whole bus trace.
    task automatic run_xfer(input bit inject);
        int  strobes = 0, dacks = 0, tends = 0, dead = 0, bad_grant = 0;
        int  bad_type = 0, bad_addr = 0, cyc = 0, k_end = -1, last_bad = -1;
        bit  seen_req = 0, injected = 0, last;
        int  nacc = exp_accesses(xfer_word, port_narrow);
        last = (e_cnt == 16'd1);
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        while (cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (injected) dreq = 1'b0;
            if (bus_req) seen_req = 1;
            if (seen_req && !bus_req) break;
            if (mem_rd || mem_wr || dack) begin
                if (!bus_grant) bad_grant++;
                if (mem_rd != !dir_to_mem || mem_wr != dir_to_mem) bad_type++;
                if (strobes % 2 == 0 &&
                    mem_addr != e_addr + 16'((strobes / 2)))
                    bad_addr++;
                if (dack) dacks++;
                if (tend) tends++;
                if (k_end >= 0 && k_end != cyc - 1) last_bad = cyc;
                k_end = cyc;
                strobes++;
                if (inject && !injected) begin dreq = 1'b1; injected = 1; end
            end else if (bus_req && strobes > 0) begin
                dead++;
            end
        end
        check(cyc < 60, "R2 transfer finished", cyc, 60);
        check(bad_grant == 0, "R3 strobes only under grant", bad_grant, 0);
        check(strobes == 2 * nacc, "R4 access cycles", strobes, 2 * nacc);
        check(bad_type == 0, "R4 strobe direction", bad_type, 0);
        check(bad_addr == 0, xfer_word && port_narrow ? "R6 byte addresses" : "R5 address",
              bad_addr, 0);
        check(dacks == strobes && last_bad < 0, "R6 dack unbroken", dacks, strobes);
        check(tends == ((tend_en && last) ? strobes : 0), "R8 tend cycles",
              tends, (tend_en && last) ? strobes : 0);
        check(dead == (last ? 1 : 0), "R9 dead cycles", dead, last ? 1 : 0);
        check(remaining == e_cnt - 16'd1, "R2 remaining", int'(remaining), int'(e_cnt) - 1);
        check(done == last, "R11 done in release", int'(done), int'(last));
        @(negedge clk);
        check(!bus_req, "R7 second low cycle", int'(bus_req), 0);
        e_cnt  = e_cnt - 16'd1;
        e_addr = e_addr + 16'(exp_advance(xfer_word));
    endtask

    task automatic quiet_window(input string req, input int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_req || dack) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    task automatic set_mode(input bit w, input bit n, input bit d, input bit t);
        @(negedge clk);
        xfer_word = w; port_narrow = n; dir_to_mem = d; tend_en = t;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({bus_req, mem_rd, mem_wr, dack, tend, done} == 6'b0, "R1 outputs idle",
              int'({bus_req, mem_rd, mem_wr, dack, tend, done}), 0);
        check(remaining == 16'd0, "R1 remaining", int'(remaining), 0);

        // R10 request with nothing to do
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        quiet_window("R10 zero count ignored", 10);

        // R5 byte read with tend, three transfers
        set_mode(0, 0, 0, 1);
        load(16'h0100, 16'd3);
        for (int i = 0; i < 3; i++) run_xfer(0);
        check(done == 1'b1, "R11 done holds", int'(done), 1);

        // R6 word on narrow port, writes
        set_mode(1, 1, 1, 1);
        load(16'h2000, 16'd2);
        for (int i = 0; i < 2; i++) run_xfer(0);

        // R5 word on wide port, tend disabled
        set_mode(1, 0, 0, 0);
        load(16'hFFFE, 16'd2);
        for (int i = 0; i < 2; i++) run_xfer(0);

        // R10 request colliding with the final transfer
        set_mode(0, 1, 0, 1);
        load(16'h0040, 16'd1);
        run_xfer(1);
        quiet_window("R10 late request dropped", 12);
        check(remaining == 16'd0, "R10 remaining stays zero", int'(remaining), 0);
        check(done == 1'b1, "R11 done after collision", int'(done), 1);

        // Random mix
        for (int r = 0; r < 25; r++) begin
            set_mode(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                     1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
            load(16'($urandom_range(16'hFFFF, 0)), 16'($urandom_range(4, 1)));
            while (e_cnt != 16'd0) begin
                repeat ($urandom_range(3, 0)) @(negedge clk);
                run_xfer(0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule